// File: doc/BRIEF.md
# Management Data Frame Engine

This block runs one clause-22 management transaction on a two-wire PHY management bus. It makes the management clock by dividing the system clock. It then shifts out one 64-bit frame: a run of idle ones, the start and opcode symbols, two 5-bit addresses, the turnaround field and 16 data bits. On a read it releases the data line at the turnaround. It takes the PHY's acknowledge and data back on the rising clock edges. It reports the result with a one-cycle done pulse.

A host loads the operation, the PHY and register addresses and the write data, then pulses `start_i`. `busy_o` stays high for the whole frame. The management clock rests low between frames. The bidirectional pad is handled outside the block through a separate output, output enable and input.

Top module: `mdio_frame_engine`

## Requirements
- R1: The management clock period equals P = div+1 system clock cycles. Each bit starts with a low phase of floor(P/2) cycles, followed by a high phase of P-floor(P/2) cycles. A divider value of 0 runs as 1, so P = 2.
- R2: A divider input larger than 0xFFFF runs as 0xFFFF, so P = 65536. The first management clock rise comes 32768 cycles after the start is accepted.
- R3: Frame bits 0..63 are sent in this order, each field MSB first:
  - bits 0..31: ones;
  - start 01;
  - opcode: 10 when `op_i`=1 (read), 01 when `op_i`=0 (write);
  - `phy_addr_i`, then `reg_addr_i`;
  - turnaround: 10 on a write;
  - `wr_data_i`.
- R4: On a read, `mdio_oe_o` is low from bit 46 (the first turnaround bit) to the end of the frame. The acknowledge is `mdio_i` being low when sampled in bit 47. Read data is sampled in bits 48..63, MSB first.
- R5: At done, a read returns `ack_o`=1 and the sampled data when acknowledged. Otherwise it returns `ack_o`=0 and `rd_data_o`=0. A write returns `ack_o`=0 and `rd_data_o`=0.
- R6: `mdio_o` changes only while the management clock is low, so it is stable through every high phase. `done_o` rises 64*P cycles after the start edge and lasts one cycle. `busy_o` is high from the start edge until done.
- R7: A start pulse while `busy_o` is high is ignored. The running frame, its timing and its single done pulse are unchanged.
- R8: While `en_i` is low, the management clock is low, `mdio_oe_o` and `busy_o` are low, and start pulses are ignored. Dropping `en_i` during a frame abandons that frame.
- R9: After reset, `busy_o`, `done_o`, `ack_o`, `mdc_o`, `mdio_oe_o` and `rd_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| div_i | input | DIV_IN_W | Clock divider value, saturated to 16 bits |
| start_i | input | 1 | One-cycle frame launch |
| op_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data, valid at done |
| ack_o | output | 1 | Read acknowledged, valid at done |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Frame in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench drives `start_i` for one cycle and counts system cycles from the accepting edge. It expects `done_o` at exactly 64*P. It expects 64 management clock rises, and a high time of 64 times the high-phase length.

Frame bits are captured on each detected clock rise, while the line is stable, and compared with the frame the bench builds from R3 and R4. The modelled PHY switches its answer one cycle after each rise, so the value the block samples is always the one meant for that bit.

The saturated divider is checked by the exact cycle of the first clock rise. The disable checks look at the outputs on the first cycle after `en_i` falls.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

    localparam int DIV_W      = 16;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int CMD_BITS   = FRAME_BITS - PRE_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } mdio_op_e;

    typedef struct packed {
        logic [DIV_W-1:0] per;
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_state_t;

    typedef struct packed {
        logic                busy;
        logic                done;
        mdio_op_e            op;
        logic [IDX_W-1:0]    idx;
        logic [CMD_BITS-1:0] cmd;
        logic [DATA_W-1:0]   rx;
        logic                ack_smp;
        logic                ack;
        logic [DATA_W-1:0]   rd;
    } seq_state_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
    import mdio_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_stb_o,
    output logic             end_stb_o
);

    div_state_t s_d, s_q;
    logic [DIV_W:0] period;
    logic [DIV_W:0] lo_len;
    logic [DIV_W:0] cnt_nx;

    always_comb begin
        period     = {1'b0, s_q.per} + 1'b1;
        lo_len     = period >> 1;
        rise_stb_o = en_i && run_i && ({1'b0, s_q.cnt} == lo_len - 1'b1);
        end_stb_o  = en_i && run_i && (s_q.cnt == s_q.per);
        cnt_nx     = end_stb_o ? '0 : {1'b0, s_q.cnt} + 1'b1;
        s_d        = s_q;
        if (!en_i) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (load_i) begin
            s_d.per = div_i;
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (run_i) begin
            s_d.cnt = cnt_nx[DIV_W-1:0];
            s_d.mdc = (cnt_nx >= lo_len);
        end else begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{per: DIV_W'(1), cnt: '0, mdc: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mdc_o = s_q.mdc;

    // R1: the phase counter never passes the latched period
    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.per);

    // R1: a bit always opens with the clock low
    a_r1_low_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        end_stb_o |=> !s_q.mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rise_stb_i,
    input  logic              end_stb_i,
    input  logic              mdio_i,
    output logic              accept_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);

    seq_state_t q_d, q_q;
    mdio_op_e   op_in;
    logic [CMD_BITS-1:0] cmd_word;
    logic [IDX_W-1:0]    sel6;
    logic                bit_val;
    logic                released;

    always_comb begin
        op_in    = mdio_op_e'(op_i);
        cmd_word = {2'b01,
                    (op_in == OP_READ) ? 2'b10 : 2'b01,
                    phy_addr_i,
                    reg_addr_i,
                    (op_in == OP_READ) ? 2'b11 : 2'b10,
                    (op_in == OP_READ) ? {DATA_W{1'b0}} : wr_data_i};
        accept_o = en_i && start_i && !q_q.busy;

        q_d      = q_q;
        q_d.done = 1'b0;
        if (!en_i) begin
            q_d.busy = 1'b0;
        end else if (accept_o) begin
            q_d.busy    = 1'b1;
            q_d.op      = op_in;
            q_d.idx     = '0;
            q_d.cmd     = cmd_word;
            q_d.rx      = '0;
            q_d.ack_smp = 1'b0;
        end else if (q_q.busy) begin
            if (rise_stb_i && q_q.op == OP_READ) begin
                if (q_q.idx == IDX_W'(TA_SECOND)) begin
                    q_d.ack_smp = !mdio_i;
                end
                if (q_q.idx >= IDX_W'(DATA_FIRST)) begin
                    q_d.rx = {q_q.rx[DATA_W-2:0], mdio_i};
                end
            end
            if (end_stb_i) begin
                if (q_q.idx == IDX_W'(FRAME_BITS - 1)) begin
                    q_d.busy = 1'b0;
                    q_d.done = 1'b1;
                    q_d.ack  = (q_q.op == OP_READ) && q_q.ack_smp;
                    q_d.rd   = ((q_q.op == OP_READ) && q_q.ack_smp) ? q_q.rx : '0;
                end else begin
                    q_d.idx = q_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{busy: 1'b0, done: 1'b0, op: OP_WRITE, idx: '0, cmd: '0,
                     rx: '0, ack_smp: 1'b0, ack: 1'b0, rd: '0};
        end else begin
            q_q <= q_d;
        end
    end

    always_comb begin
        sel6      = IDX_W'(FRAME_BITS - 1) - q_q.idx;
        bit_val   = (q_q.idx < IDX_W'(PRE_BITS)) ? 1'b1 : q_q.cmd[sel6[$clog2(CMD_BITS)-1:0]];
        released  = (q_q.op == OP_READ) && (q_q.idx >= IDX_W'(TA_FIRST));
        mdio_o    = q_q.busy && bit_val;
        mdio_oe_o = q_q.busy && en_i && !released;
        busy_o    = q_q.busy;
        done_o    = q_q.done;
        ack_o     = q_q.ack;
        rd_data_o = q_q.rd;
    end

    // R7: a start during a frame leaves the frame contents alone
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.busy && start_i) |=> $stable(q_q.cmd));

    // R6: done lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.done |=> !q_q.done);

    // R6: done only when the frame has ended
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.done |-> !q_q.busy);

    // R5: a missing acknowledge never returns data
    a_r5_nack_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.done && !q_q.ack) |-> (q_q.rd == '0));

    // R4: line released through the read turnaround and data phase
    a_r4_release_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.busy && q_q.op == OP_READ && q_q.idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe_o);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_eng_pkg::*;
#(
    parameter int DIV_IN_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [DIV_IN_W-1:0] div_i,
    input  logic                start_i,
    input  logic                op_i,
    input  logic [ADDR_W-1:0]   phy_addr_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                ack_o,
    output logic                done_o,
    output logic                busy_o,
    output logic                mdc_o,
    output logic                mdio_o,
    output logic                mdio_oe_o,
    input  logic                mdio_i
);

    logic [DIV_W-1:0] div_sat;
    logic [DIV_W-1:0] div_eff;
    logic             accept;
    logic             rise_stb;
    logic             end_stb;

    generate
        if (DIV_IN_W > DIV_W) begin : g_sat
            assign div_sat = (|div_i[DIV_IN_W-1:DIV_W]) ? {DIV_W{1'b1}} : div_i[DIV_W-1:0];
        end else begin : g_ext
            assign div_sat = DIV_W'(div_i);
        end
    endgenerate

    assign div_eff = (div_sat == '0) ? DIV_W'(1) : div_sat;

    mdio_clk_div u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .load_i     (accept),
        .run_i      (busy_o),
        .div_i      (div_eff),
        .mdc_o      (mdc_o),
        .rise_stb_o (rise_stb),
        .end_stb_o  (end_stb)
    );

    mdio_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .start_i    (start_i),
        .op_i       (op_i),
        .phy_addr_i (phy_addr_i),
        .reg_addr_i (reg_addr_i),
        .wr_data_i  (wr_data_i),
        .rise_stb_i (rise_stb),
        .end_stb_i  (end_stb),
        .mdio_i     (mdio_i),
        .accept_o   (accept),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ack_o      (ack_o),
        .rd_data_o  (rd_data_o),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o)
    );

    // R8: disabling silences clock, driver and busy on the next cycle
    a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!mdc_o && !mdio_oe_o && !busy_o));

    // R6: the clock is back low when the frame completes
    a_r6_mdc_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mdc_o);

    // R6: the data line holds while the clock is high
    a_r6_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mdc_o && $past(mdc_o) && $past(busy_o)) |-> $stable(mdio_o));

endmodule

// File: tb/mdio_frame_engine_bench.sv
module mdio_frame_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [19:0] div_i = '0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        ack_o, done_o, busy_o, mdc_o, mdio_o, mdio_oe_o;
    logic        mdio_i;

    int total = 0;
    int bad = 0;

    // PHY model state
    logic        rd_mode = 1'b0;
    logic        p_ack = 1'b0;
    logic [15:0] p_data = '0;
    int          rises = 0;
    int          viol = 0;
    logic [63:0] cap = '0;
    logic [63:0] oe_cap = '0;
    logic        mdc_prev = 1'b0;
    logic        o_prev = 1'b0;
    logic        phy_val;

    always #2.5 clk = ~clk;

    mdio_frame_engine u_mdio_frame_engine (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_i(div_i), .start_i(start_i),
        .op_i(op_i), .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .ack_o(ack_o),
        .done_o(done_o), .busy_o(busy_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
        .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    always_comb begin
        phy_val = 1'b1;
        if (rd_mode && rises == 47) phy_val = !p_ack;
        else if (rd_mode && p_ack && rises >= 48 && rises <= 63) phy_val = p_data[63 - rises];
    end

    assign mdio_i = mdio_oe_o ? mdio_o : phy_val;

    always @(posedge clk) begin
        mdc_prev <= mdc_o;
        o_prev   <= mdio_o;
        if (start_i && en_i && !busy_o) begin
            rises <= 0;
            viol  <= 0;
        end else begin
            if (mdc_o && !mdc_prev) begin
                cap    <= {cap[62:0], mdio_i};
                oe_cap <= {oe_cap[62:0], mdio_oe_o};
                rises  <= rises + 1;
            end
            if (busy_o && mdc_o && mdc_prev && mdio_o != o_prev) viol <= viol + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                                               input logic [15:0] wd, input bit ak, input logic [15:0] pd);
        if (rd) exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 1'b1, !ak, ak ? pd : 16'hFFFF};
        else    exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd};
    endfunction

    int cycles;
    int highs;

    // launch one frame; optionally inject a second start at cycle inj
    task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                             input logic [19:0] dv, input bit ak, input logic [15:0] pd, input int inj);
        @(negedge clk);
        rd_mode = rd; p_ack = ak; p_data = pd;
        op_i = rd; phy_addr_i = pa; reg_addr_i = ra; wr_data_i = wd; div_i = dv;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cycles = 0; highs = 0;
        while (!done_o && cycles < 20000) begin
            if (cycles == inj) begin
                start_i = 1'b1; op_i = !rd; phy_addr_i = ~pa; wr_data_i = ~wd;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cycles++;
            if (mdc_o) highs++;
        end
        start_i = 1'b0;
    endtask

    task automatic check_frame(input string tag, input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                               input logic [15:0] wd, input int p, input bit ak, input logic [15:0] pd);
        logic [63:0] oe_exp;
        oe_exp = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
        chk(cycles == 64 * p, {tag, " R6 done cycle"}, 64'(cycles), 64'(64 * p));
        chk(highs == 64 * (p - p / 2), {tag, " R1 high time"}, 64'(highs), 64'(64 * (p - p / 2)));
        chk(rises == 64, {tag, " R1 clock rises"}, 64'(rises), 64'd64);
        chk(cap == exp_frame(rd, pa, ra, wd, ak, pd), {tag, " R3 frame bits"}, cap, exp_frame(rd, pa, ra, wd, ak, pd));
        chk(oe_cap == oe_exp, {tag, " R4 output enable"}, oe_cap, oe_exp);
        chk(viol == 0, {tag, " R6 stable while high"}, 64'(viol), 64'd0);
        chk(ack_o == (rd && ak), {tag, " R5 ack"}, 64'(ack_o), 64'(rd && ak));
        chk(rd_data_o == ((rd && ak) ? pd : 16'h0), {tag, " R5 read data"}, 64'(rd_data_o), 64'((rd && ak) ? pd : 16'h0));
        chk(!busy_o, {tag, " R6 busy low at done"}, 64'(busy_o), 64'd0);
        @(negedge clk);
        chk(!done_o, {tag, " R6 done one cycle"}, 64'(done_o), 64'd0);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !ack_o && !mdc_o && !mdio_oe_o && rd_data_o == 0,
            "R9 reset state", {busy_o, done_o, ack_o, mdc_o, mdio_oe_o, rd_data_o}, 64'd0);
    endtask

    task automatic t_write();
        run_frame(1'b0, 5'h15, 5'h0A, 16'hBEEF, 20'd1, 1'b0, 16'h0, -1);
        check_frame("write", 1'b0, 5'h15, 5'h0A, 16'hBEEF, 2, 1'b0, 16'h0);
    endtask

    task automatic t_read_ack();
        run_frame(1'b1, 5'h03, 5'h1F, 16'h0, 20'd4, 1'b1, 16'hA5C3, -1);
        check_frame("read ack", 1'b1, 5'h03, 5'h1F, 16'h0, 5, 1'b1, 16'hA5C3);
    endtask

    task automatic t_read_nack();
        run_frame(1'b1, 5'h1C, 5'h01, 16'h0, 20'd3, 1'b0, 16'h1234, -1);
        check_frame("read nack", 1'b1, 5'h1C, 5'h01, 16'h0, 4, 1'b0, 16'h1234);
    endtask

    task automatic t_div_zero();
        run_frame(1'b0, 5'h00, 5'h00, 16'h8001, 20'd0, 1'b0, 16'h0, -1);
        check_frame("div zero R1", 1'b0, 5'h00, 5'h00, 16'h8001, 2, 1'b0, 16'h0);
    endtask

    task automatic t_busy_start();
        run_frame(1'b0, 5'h0F, 5'h11, 16'h5A5A, 20'd2, 1'b0, 16'h0, 40);
        check_frame("R7 start while busy", 1'b0, 5'h0F, 5'h11, 16'h5A5A, 3, 1'b0, 16'h0);
    endtask

    task automatic t_disable();
        @(negedge clk);
        en_i = 1'b0; start_i = 1'b1; op_i = 1'b0; div_i = 20'd1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(!busy_o && !mdc_o && !mdio_oe_o, "R8 start ignored when disabled",
            {busy_o, mdc_o, mdio_oe_o}, 64'd0);
        en_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy_o && mdio_oe_o, "R8 frame running before disable", {busy_o, mdio_oe_o}, 64'd3);
        en_i = 1'b0;
        @(negedge clk);
        chk(!busy_o && !mdc_o && !mdio_oe_o, "R8 disable mid frame", {busy_o, mdc_o, mdio_oe_o}, 64'd0);
        repeat (5) @(negedge clk);
        chk(!done_o, "R8 no done after abort", 64'(done_o), 64'd0);
        en_i = 1'b1;
    endtask

    task automatic t_saturate();
        int n;
        @(negedge clk);
        op_i = 1'b0; div_i = 20'h12345; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!mdc_o && n < 70000) begin
            @(negedge clk);
            n++;
        end
        chk(n == 32768, "R2 saturated first rise", 64'(n), 64'd32768);
        en_i = 1'b0;
        @(negedge clk);
        en_i = 1'b1;
        @(negedge clk);
    endtask

    bit finished = 1'b0;

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        en_i = 1'b1;
        @(negedge clk);
        t_write();
        t_read_ack();
        t_read_nack();
        t_div_zero();
        t_busy_start();
        t_disable();
        t_saturate();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule